// File: doc/BRIEF.md
# Paged Register Access Front End

This block sits between a word-oriented serial host link and a bank of register pages. The host sends 16-bit words. The block alternates between two states. In the command state a word is decoded into a direction flag, a page number and a register offset. In the data state the next word is the payload for a write. A read is requested separately. The block returns the word from the addressed register and then advances the offset by one, so the host can walk through neighbouring registers with repeated read requests.

The register side is a simple strobe bus. It carries a page, an offset, a write enable with write data, and a read enable whose data comes back on the same cycle. An access-done pulse goes with every real bus access, so that downstream logic can re-evaluate its interrupt and conversion state. There are three sticky error flags that stay set until a synchronous clear. One flags a data word that arrives behind a read command. One flags a read request made while the latched command is a write. One flags an access aimed at a page that does not exist.

Top module: `pgreg_frontend`

## Requirements
- R1: In a command word, bit 15 is the read flag (1 = read), bits 14:11 are the page and bits 10:5 are the offset; bits 4:0 are ignored. A command word causes no bus strobe, and its page and offset are the ones used by the accesses that follow.
- R2: A word that follows a write command to a valid page produces, in the next cycle, exactly one cycle of `bus_we` and `bus_done` with the latched page and offset and `bus_wdat` equal to that word. The block then returns to the command state.
- R3: A word that follows a read command is not written (no `bus_we`, no `bus_done`). It sets `err_ovr` in the next cycle, and the block returns to the command state.
- R4: A read request made while the latched command is a write sets `err_und` in the next cycle, and the read is still performed.
- R5: A read request to a valid page gives one cycle of `bus_re` and `bus_done` in the next cycle, with the latched page and offset. One cycle later `rd_vld` pulses with `rd_dat` equal to the `bus_rdat` returned during the `bus_re` cycle.
- R6: Every read request increments the latched offset by one, modulo 64 (63 wraps to 0), and returns the block to the command state. Consecutive read requests therefore address consecutive offsets.
- R7: Only pages 0, 1 and 2 are valid. A write or read aimed at any other page gives no `bus_we`, `bus_re` or `bus_done` and sets `err_bad`. Such a read still answers with `rd_vld` and `rd_dat` = 16'hFFFF.
- R8: `err_ovr`, `err_und` and `err_bad` stay set until `err_clr` is sampled high, and they read 0 the cycle after. When a new error and `err_clr` arrive in the same cycle, the flag ends up set.
- R9: Reset puts the block in the command state with the latched command set to write, page 0 and offset 0. All strobes, `rd_vld`, `rd_dat`, the bus address and the error flags are 0.
- R10: When `word_vld` and `rd_req` are sampled together, the read is serviced and the word is dropped: it is neither latched as a command nor written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_clr | input | 1 | Synchronous clear of the sticky error flags |
| word_vld | input | 1 | A host word is present on `word_dat` |
| word_dat | input | 16 | Host word: command or write data |
| rd_req | input | 1 | Host read request |
| rd_vld | output | 1 | Read data valid pulse |
| rd_dat | output | 16 | Read data returned to the host |
| bus_page | output | 4 | Register bus page |
| bus_ofs | output | 6 | Register bus offset |
| bus_we | output | 1 | Register write strobe |
| bus_wdat | output | 16 | Register write data |
| bus_re | output | 1 | Register read strobe |
| bus_rdat | input | 16 | Register read data, valid while `bus_re` is high |
| bus_done | output | 1 | Access-done pulse for each completed bus access |
| err_ovr | output | 1 | Sticky: data word followed a read command |
| err_und | output | 1 | Sticky: read requested under a write command |
| err_bad | output | 1 | Sticky: access to a nonexistent page |

## Verification
The bench builds the block with its defaults: a 16-bit word, a 4-bit page field, a 6-bit offset and three valid pages. A 6-bit offset means a wrap from 63 to 0 takes at most two read requests after one targeted command. A 4-bit page field with only three valid values leaves thirteen nonexistent pages, which the random stimulus hits often. The bench also places collisions of a word and a read request, and error clears that coincide with new errors, at chosen points in the stream.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;

  typedef enum logic {
    ST_CMD  = 1'b0,
    ST_DATA = 1'b1
  } seq_st_e;

  // Per-cycle outcome of the sequencer
  typedef struct packed {
    logic wr;   // bus write issued
    logic rd;   // bus read issued
    logic ovr;  // data word under a read command
    logic und;  // read request under a write command
    logic bad;  // access to a nonexistent page
  } acc_ev_t;

  localparam int ERR_OVR = 0;
  localparam int ERR_UND = 1;
  localparam int ERR_BAD = 2;
  localparam int ERR_N   = 3;

endpackage

// File: rtl/pgreg_cmd_dec.sv
module pgreg_cmd_dec #(
  parameter int WORD_W = 16,
  parameter int PAGE_W = 4,
  parameter int OFS_W  = 6
) (
  input  logic [WORD_W-1:0] word,
  output logic              dir_rd,
  output logic [PAGE_W-1:0] page,
  output logic [OFS_W-1:0]  ofs
);
  localparam int RD_POS   = WORD_W - 1;
  localparam int PAGE_LSB = RD_POS - PAGE_W;
  localparam int OFS_LSB  = PAGE_LSB - OFS_W;

  assign dir_rd = word[RD_POS];
  assign page   = word[RD_POS-1:PAGE_LSB];
  assign ofs    = word[PAGE_LSB-1:OFS_LSB];

  // Low bits below the offset field carry no meaning
  generate
    if (OFS_LSB > 0) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^word[OFS_LSB-1:0];
    end
  endgenerate
endmodule

// File: rtl/pgreg_page_chk.sv
module pgreg_page_chk #(
  parameter int PAGE_W    = 4,
  parameter int NUM_PAGES = 3
) (
  input  logic [PAGE_W-1:0] page,
  output logic              ok
);
  localparam int PAGE_SPAN = 1 << PAGE_W;

  generate
    if (NUM_PAGES >= PAGE_SPAN) begin : g_all
      logic unused_page;
      assign unused_page = ^page;
      assign ok = 1'b1;
    end else begin : g_cmp
      localparam logic [PAGE_W-1:0] LAST = PAGE_W'(NUM_PAGES - 1);
      assign ok = (page <= LAST);
    end
  endgenerate
endmodule

// File: rtl/pgreg_err.sv
module pgreg_err #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] flag
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)         flag[i] <= 1'b0;
        else if (set[i]) flag[i] <= 1'b1;   // a new event wins over clear
        else if (clr)    flag[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/pgreg_seq.sv
module pgreg_seq
  import pgreg_pkg::*;
#(
  parameter int PAGE_W    = 4,
  parameter int OFS_W     = 6,
  parameter int NUM_PAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic              rd_req,
  input  logic              dec_rd,
  input  logic [PAGE_W-1:0] dec_page,
  input  logic [OFS_W-1:0]  dec_ofs,
  output logic [PAGE_W-1:0] cmd_page,
  output logic [OFS_W-1:0]  cmd_ofs,
  output acc_ev_t           ev
);
  seq_st_e st;
  logic    cmd_rd;
  logic    page_ok;
  logic    word_cmd;
  logic    word_dat;

  pgreg_page_chk #(.PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES)) u_page_chk (
    .page (cmd_page),
    .ok   (page_ok)
  );

  // A read request takes the cycle; a colliding word is dropped
  always_comb begin
    word_cmd = word_vld && !rd_req && (st == ST_CMD);
    word_dat = word_vld && !rd_req && (st == ST_DATA);
    ev.wr  = word_dat && !cmd_rd && page_ok;
    ev.ovr = word_dat && cmd_rd;
    ev.rd  = rd_req && page_ok;
    ev.und = rd_req && !cmd_rd;
    ev.bad = !page_ok && (rd_req || (word_dat && !cmd_rd));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_CMD;
      cmd_rd   <= 1'b0;
      cmd_page <= '0;
      cmd_ofs  <= '0;
    end else if (rd_req) begin
      cmd_ofs <= cmd_ofs + OFS_W'(1);
      st      <= ST_CMD;
    end else if (word_cmd) begin
      cmd_rd   <= dec_rd;
      cmd_page <= dec_page;
      cmd_ofs  <= dec_ofs;
      st       <= ST_DATA;
    end else if (word_dat) begin
      st <= ST_CMD;
    end
  end
endmodule

// File: rtl/pgreg_frontend.sv
module pgreg_frontend
  import pgreg_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int PAGE_W    = 4,
  parameter int OFS_W     = 6,
  parameter int NUM_PAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_clr,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_dat,
  input  logic              rd_req,
  output logic              rd_vld,
  output logic [WORD_W-1:0] rd_dat,
  output logic [PAGE_W-1:0] bus_page,
  output logic [OFS_W-1:0]  bus_ofs,
  output logic              bus_we,
  output logic [WORD_W-1:0] bus_wdat,
  output logic              bus_re,
  input  logic [WORD_W-1:0] bus_rdat,
  output logic              bus_done,
  output logic              err_ovr,
  output logic              err_und,
  output logic              err_bad
);
  logic              dec_rd;
  logic [PAGE_W-1:0] dec_page;
  logic [OFS_W-1:0]  dec_ofs;
  logic [PAGE_W-1:0] cmd_page;
  logic [OFS_W-1:0]  cmd_ofs;
  acc_ev_t           ev;
  logic [ERR_N-1:0]  err_set;
  logic [ERR_N-1:0]  err_q;
  logic              rp_vld;
  logic              rp_bad;

  pgreg_cmd_dec #(.WORD_W(WORD_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_dec (
    .word   (word_dat),
    .dir_rd (dec_rd),
    .page   (dec_page),
    .ofs    (dec_ofs)
  );

  pgreg_seq #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .NUM_PAGES(NUM_PAGES)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .word_vld (word_vld),
    .rd_req   (rd_req),
    .dec_rd   (dec_rd),
    .dec_page (dec_page),
    .dec_ofs  (dec_ofs),
    .cmd_page (cmd_page),
    .cmd_ofs  (cmd_ofs),
    .ev       (ev)
  );

  always_comb begin
    err_set          = '0;
    err_set[ERR_OVR] = ev.ovr;
    err_set[ERR_UND] = ev.und;
    err_set[ERR_BAD] = ev.bad;
  end

  pgreg_err #(.N(ERR_N)) u_err (
    .clk  (clk),
    .rst  (rst),
    .clr  (err_clr),
    .set  (err_set),
    .flag (err_q)
  );

  assign err_ovr = err_q[ERR_OVR];
  assign err_und = err_q[ERR_UND];
  assign err_bad = err_q[ERR_BAD];

  // Registered bus side
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_we   <= 1'b0;
      bus_re   <= 1'b0;
      bus_done <= 1'b0;
      bus_page <= '0;
      bus_ofs  <= '0;
      bus_wdat <= '0;
    end else begin
      bus_we   <= ev.wr;
      bus_re   <= ev.rd;
      bus_done <= ev.wr | ev.rd;
      if (ev.wr | ev.rd) begin
        bus_page <= cmd_page;
        bus_ofs  <= cmd_ofs;
      end
      if (ev.wr) bus_wdat <= word_dat;
    end
  end

  // Read return: capture bus data during the strobe cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      rp_vld <= 1'b0;
      rp_bad <= 1'b0;
      rd_vld <= 1'b0;
      rd_dat <= '0;
    end else begin
      rp_vld <= rd_req;
      rp_bad <= rd_req && !ev.rd;
      rd_vld <= rp_vld;
      if (rp_vld) rd_dat <= rp_bad ? '1 : bus_rdat;
    end
  end
endmodule

// File: rtl/pgreg_frontend_chk.sv
module pgreg_frontend_chk #(
  parameter int PAGE_W    = 4,
  parameter int NUM_PAGES = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              err_clr,
  input logic              word_vld,
  input logic              rd_req,
  input logic              rd_vld,
  input logic [PAGE_W-1:0] bus_page,
  input logic              bus_we,
  input logic              bus_re,
  input logic              bus_done,
  input logic              err_ovr,
  input logic              err_und,
  input logic              err_bad
);
  AST_WE_NOT_RE: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> !bus_re); // R2
  AST_DONE_HAS_STROBE: assert property (@(posedge clk) disable iff (rst)
    bus_done |-> (bus_we || bus_re)); // R2
  AST_WE_FROM_WORD: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> ($past(word_vld) && !$past(rd_req))); // R10
  AST_RE_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    bus_re |-> $past(rd_req)); // R5
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> rd_vld); // R5
  AST_PAGE_EXISTS: assert property (@(posedge clk) disable iff (rst)
    (bus_we || bus_re) |-> (int'(bus_page) < NUM_PAGES)); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_ovr && !err_clr) |=> err_ovr); // R8
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(err_ovr) |-> $past(word_vld)); // R3
  AST_UND_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(err_und) |-> $past(rd_req)); // R4
  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !rd_req && !word_vld) |=> (!err_ovr && !err_und && !err_bad)); // R8
endmodule

bind pgreg_frontend pgreg_frontend_chk #(.PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .err_clr  (err_clr),
  .word_vld (word_vld),
  .rd_req   (rd_req),
  .rd_vld   (rd_vld),
  .bus_page (bus_page),
  .bus_we   (bus_we),
  .bus_re   (bus_re),
  .bus_done (bus_done),
  .err_ovr  (err_ovr),
  .err_und  (err_und),
  .err_bad  (err_bad)
);

// File: tb/tb_pgreg_frontend.sv
`timescale 1ns/1ps
module tb_pgreg_frontend;
  localparam int WORD_W = 16;
  localparam int PAGE_W = 4;
  localparam int OFS_W  = 6;
  localparam int NPG    = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst, err_clr, word_vld, rd_req;
  logic [WORD_W-1:0] word_dat, rd_dat, bus_wdat, bus_rdat;
  logic              rd_vld, bus_we, bus_re, bus_done, err_ovr, err_und, err_bad;
  logic [PAGE_W-1:0] bus_page;
  logic [OFS_W-1:0]  bus_ofs;

  pgreg_frontend #(.WORD_W(WORD_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W), .NUM_PAGES(NPG)) dut (
    .clk(clk), .rst(rst), .err_clr(err_clr), .word_vld(word_vld), .word_dat(word_dat),
    .rd_req(rd_req), .rd_vld(rd_vld), .rd_dat(rd_dat), .bus_page(bus_page),
    .bus_ofs(bus_ofs), .bus_we(bus_we), .bus_wdat(bus_wdat), .bus_re(bus_re),
    .bus_rdat(bus_rdat), .bus_done(bus_done), .err_ovr(err_ovr), .err_und(err_und),
    .err_bad(err_bad)
  );

  // Register file behind the bus, driven by the DUT strobes
  logic [15:0] regs    [0:255];
  logic [15:0] exp_mem [0:255];
  assign bus_rdat = (int'(bus_page) < NPG) ? regs[{bus_page[1:0], bus_ofs}] : 16'hdead;
  always @(posedge clk) if (bus_we && int'(bus_page) < NPG) regs[{bus_page[1:0], bus_ofs}] <= bus_wdat;

  int n_chk = 0;
  int n_fail = 0;

  // Reference model state
  bit         m_st, m_rd, m_ovr, m_und, m_bad;
  logic [3:0] m_pg;
  logic [5:0] m_of;

  function automatic logic [15:0] mkcmd(input bit rd, input logic [3:0] pg, input logic [5:0] of);
    return {rd, pg, of, 5'($urandom)};
  endfunction

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", r, what, act, exp);
    end
  endtask

  task automatic chk_flags(input string r);
    chk(err_ovr == m_ovr, r, "err_ovr", err_ovr, m_ovr);
    chk(err_und == m_und, r, "err_und", err_und, m_und);
    chk(err_bad == m_bad, r, "err_bad", err_bad, m_bad);
  endtask

  task automatic hw_word(input logic [15:0] w, input bit clr = 1'b0);
    @(negedge clk); word_vld = 1'b1; word_dat = w; err_clr = clr;
    @(negedge clk); word_vld = 1'b0; err_clr = 1'b0;
    if (clr) begin m_ovr = 0; m_und = 0; m_bad = 0; end
    if (!m_st) begin
      m_rd = w[15]; m_pg = w[14:11]; m_of = w[10:5]; m_st = 1'b1;
      chk(!bus_we && !bus_re && !bus_done, "R1", "strobe on command", {bus_we, bus_re, bus_done}, 0);
    end else begin
      m_st = 1'b0;
      if (m_rd) begin
        m_ovr = 1'b1;
        chk(!bus_we && !bus_done, "R3", "write under read cmd", {bus_we, bus_done}, 0);
      end else if (int'(m_pg) >= NPG) begin
        m_bad = 1'b1;
        chk(!bus_we && !bus_re && !bus_done, "R7", "write to bad page", {bus_we, bus_done}, 0);
      end else begin
        chk(bus_we && bus_done && !bus_re, "R2", "write strobe", {bus_we, bus_re, bus_done}, 3'b101);
        chk(bus_page == m_pg, "R1", "write page", bus_page, m_pg);
        chk(bus_ofs == m_of, "R1", "write offset", bus_ofs, m_of);
        chk(bus_wdat == w, "R2", "write data", bus_wdat, w);
        exp_mem[{m_pg[1:0], m_of}] = w;
      end
    end
    chk_flags(clr ? "R8" : "R3");
  endtask

  task automatic hw_read(input bit clr = 1'b0, input bit with_word = 1'b0,
                         input logic [15:0] w = 16'h0);
    logic [15:0] exp;
    @(negedge clk); rd_req = 1'b1; err_clr = clr;
    if (with_word) begin word_vld = 1'b1; word_dat = w; end
    @(negedge clk); rd_req = 1'b0; word_vld = 1'b0; err_clr = 1'b0;
    if (clr) begin m_ovr = 0; m_und = 0; m_bad = 0; end
    if (!m_rd) m_und = 1'b1;
    if (int'(m_pg) >= NPG) begin
      m_bad = 1'b1;
      exp = 16'hffff;
      chk(!bus_re && !bus_we && !bus_done, "R7", "read of bad page strobes", {bus_we, bus_re, bus_done}, 0);
    end else begin
      exp = exp_mem[{m_pg[1:0], m_of}];
      chk(bus_re && bus_done && !bus_we, "R5", "read strobe", {bus_we, bus_re, bus_done}, 3'b011);
      chk(bus_page == m_pg, "R5", "read page", bus_page, m_pg);
      chk(bus_ofs == m_of, "R6", "read offset", bus_ofs, m_of);
    end
    if (with_word) chk(!bus_we, "R10", "word beside read", bus_we, 0);
    chk_flags(clr ? "R8" : "R4");
    m_of = m_of + 6'd1;
    m_st = 1'b0;
    @(negedge clk);
    chk(rd_vld && !bus_re, "R5", "rd_vld timing", {rd_vld, bus_re}, 2'b10);
    chk(rd_dat == exp, (exp == 16'hffff && int'(m_pg) >= NPG) ? "R7" : "R5", "rd_dat", rd_dat, exp);
  endtask

  task automatic clear_flags();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    m_ovr = 0; m_und = 0; m_bad = 0;
    chk_flags("R8");
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all-requirements act=timeout exp=finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      regs[i]    = 16'(i * 16'h0123) ^ 16'h5a3c;
      exp_mem[i] = 16'(i * 16'h0123) ^ 16'h5a3c;
    end
    rst = 1'b1; err_clr = 1'b0; word_vld = 1'b0; rd_req = 1'b0; word_dat = '0;
    m_st = 0; m_rd = 0; m_pg = 0; m_of = 0; m_ovr = 0; m_und = 0; m_bad = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(!bus_we && !bus_re && !bus_done && !rd_vld, "R9", "strobes after reset",
        {bus_we, bus_re, bus_done, rd_vld}, 0);
    chk(rd_dat == 0 && bus_page == 0 && bus_ofs == 0, "R9", "bus/data after reset",
        {bus_page, bus_ofs, rd_dat}, 0);
    chk_flags("R9");
    // R9: latched command is a write at page 0, offset 0
    hw_read();
    chk(err_und, "R9", "reset command is write", err_und, 1);
    clear_flags();

    // R1/R2/R5/R6: write then burst-read back
    hw_word(mkcmd(0, 4'd1, 6'd5));
    hw_word(16'h1234);
    hw_word(mkcmd(0, 4'd1, 6'd6));
    hw_word(16'hbeef);
    hw_word(mkcmd(1, 4'd1, 6'd5));
    hw_read(); hw_read(); hw_read();

    // R6: wrap from 63 to 0
    hw_word(mkcmd(0, 4'd2, 6'd63));
    hw_word(16'hcafe);
    hw_word(mkcmd(1, 4'd2, 6'd63));
    hw_read(); hw_read();

    // R6: after a read, next word is a command
    hw_word(mkcmd(1, 4'd0, 6'd10));
    hw_read();
    hw_word(mkcmd(0, 4'd0, 6'd12));
    hw_word(16'h0f0f);

    // R3: overrun, then register untouched
    hw_word(mkcmd(1, 4'd2, 6'd7));
    hw_word(16'h7777);
    hw_read();
    clear_flags();

    // R4: underrun still reads
    hw_word(mkcmd(0, 4'd0, 6'd20));
    hw_read();

    // R8: new error together with clear stays set
    hw_read(1'b1);
    chk(err_und, "R8", "set wins over clear", err_und, 1);
    clear_flags();

    // R7: nonexistent pages
    hw_word(mkcmd(0, 4'd3, 6'd1));
    hw_word(16'h5555);
    hw_word(mkcmd(1, 4'd15, 6'd2));
    hw_read();
    clear_flags();

    // R10: word collides with read in the data state
    hw_word(mkcmd(0, 4'd1, 6'd30));
    hw_read(1'b0, 1'b1, 16'h9999);
    hw_word(mkcmd(1, 4'd1, 6'd30));
    hw_read();
    clear_flags();

    // Random traffic
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [3:0] pg;
      logic [5:0] of;
      op = int'($urandom % 6);
      pg = ($urandom % 8 == 0) ? 4'(3 + $urandom % 13) : 4'($urandom % 3);
      of = 6'($urandom);
      case (op)
        0, 1: begin hw_word(mkcmd(0, pg, of)); hw_word(16'($urandom)); end
        2, 3: begin
          hw_word(mkcmd(1, pg, of));
          for (int k = 0; k < 1 + int'($urandom % 4); k++) hw_read();
        end
        4: begin hw_word(mkcmd(1, pg, of)); hw_word(16'($urandom)); end
        default: hw_read(1'b0, ($urandom % 3 == 0), 16'($urandom));
      endcase
      if (i % 50 == 49) clear_flags();
    end

    summary();
    $finish;
  end
endmodule